// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

This block collects request pulses from a set of maskable interrupt sources and chooses which one the processor should take next. Each source has a sticky pending flag and a three-bit priority level. A single global enable gates every source. The processor supplies its current priority level, and a source is eligible only when its level is strictly above that value. Among the eligible sources, the one with the highest level wins. When several share that level, the lowest index wins. The winner is presented on registered outputs as a request line with the source index and its level.

The processor answers with an acknowledge strobe. That strobe clears the pending flag of the source that was presented in the same cycle. A small register port lets software write the global enable and the per-source levels, and clear pending flags by writing zeros. Writing a one never sets a flag. Vector fetch, context saving and the update of the processor level after acceptance are handled elsewhere.

Top module: `prio_irq_ctrl`

## Requirements
- R1: When the global enable (address 0, bit 0) is 0, `irqReq` stays low whatever flags, levels and processor level hold.
- R2: A one on `srcPulse[i]` at a clock edge sets pending flag i. With the source eligible and the request line free, `irqReq` rises at the next edge.
- R3: A write to address 1 clears pending flag i where data bit i is 0 and leaves it unchanged where bit i is 1. A write never sets a flag. A read of address 1 returns the flags in bits [N-1:0].
- R4: The level of source i is held at address 2+i in bits [2:0]. Level 0 keeps the source from ever being chosen.
- R5: A source is eligible only if enable is 1, its flag is 1 and its level is strictly greater than `cpuLevel`. A `cpuLevel` of 7 blocks every source.
- R6: Among eligible sources the highest level wins. On equal levels the lowest index wins.
- R7: `irqReq`, `irqIdx` and `irqLvl` are registered from the state before the edge. While `irqReq` is 0, `irqIdx` and `irqLvl` are 0.
- R8: A request pulse in the same cycle as a software clear or an acknowledge of that flag leaves the flag set.
- R9: `irqAck` while `irqReq` is 1 clears only the flag of the source on `irqIdx` and drives `irqReq` low for the next cycle. `irqAck` while `irqReq` is 0 has no effect.
- R10: Enable, pending flags, levels and `cpuLevel` are independent. A write to one changes none of the others, and writes to addresses above 1+N are ignored.
- R11: After reset the enable, all flags, all levels and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcPulse | input | NUM_SRC | Request pulses, one per source |
| cpuLevel | input | 3 | Processor's current priority level |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register address for read and write |
| regWrData | input | DATA_W | Register write data |
| regRdData | output | DATA_W | Register read data (combinational from regAddr) |
| irqAck | input | 1 | Processor accepts the presented request |
| irqReq | output | 1 | Interrupt request to the processor |
| irqIdx | output | $clog2(NUM_SRC) | Index of the presented source |
| irqLvl | output | 3 | Level of the presented source |

## Verification
Properties in the datapath check the following on every cycle:
- a flag rises only after a request pulse;
- a pulse always leaves its flag set;
- a presented request had the enable on and a level above the previous processor level;
- an acknowledge drops the request line;
- the idle outputs are zero.

The tie-break toward the lowest index, the choice of the highest level, the write-one-is-ignored rule seen through readback, and the independence of the stored fields can only be shown by the bench. The bench compares every cycle against its own model of the acceptance rules, replays hand-computed vectors, and runs directed readback scenarios.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int LVL_W = 3;
  localparam int LVL_BASE = 2;

  typedef struct packed {
    logic wrEn;
    logic selEn;
    logic selPend;
    logic selLvl;
    logic ackFire;
  } irqStrobe_t;
endpackage

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int ADDR_W = 4,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              irqAck,
  input  logic              irqReqQ,
  output irqStrobe_t        strobe,
  output logic [IDX_W-1:0]  lvlSel
);
  localparam int LVL_END = LVL_BASE + NUM_SRC;

  always_comb begin
    strobe.wrEn    = regWrEn;
    strobe.selEn   = (regAddr == ADDR_W'(0));
    strobe.selPend = (regAddr == ADDR_W'(1));
    strobe.selLvl  = (int'(regAddr) >= LVL_BASE) && (int'(regAddr) < LVL_END);
    strobe.ackFire = irqAck & irqReqQ;
    lvlSel = IDX_W'(regAddr - ADDR_W'(LVL_BASE));
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 8,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                            globalEn,
  input  logic [NUM_SRC-1:0]              flags,
  input  logic [NUM_SRC-1:0][LVL_W-1:0]   levels,
  input  logic [LVL_W-1:0]                cpuLevel,
  output logic                            pickValid,
  output logic [IDX_W-1:0]                pickIdx,
  output logic [LVL_W-1:0]                pickLvl
);
  logic [NUM_SRC-1:0] eligible;

  for (genvar g = 0; g < NUM_SRC; g++) begin : gElig
    assign eligible[g] = globalEn & flags[g] & (levels[g] > cpuLevel);
  end

  // strict compare keeps the earlier (lower) index on equal levels
  always_comb begin
    pickValid = 1'b0;
    pickIdx   = '0;
    pickLvl   = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (eligible[i] && (!pickValid || levels[i] > pickLvl)) begin
        pickValid = 1'b1;
        pickIdx   = IDX_W'(i);
        pickLvl   = levels[i];
      end
    end
  end
endmodule

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int DATA_W = 8,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  irqStrobe_t         strobe,
  input  logic [IDX_W-1:0]   lvlSel,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [NUM_SRC-1:0] srcPulse,
  input  logic [LVL_W-1:0]   cpuLevel,
  output logic [DATA_W-1:0]  rdData,
  output logic               irqReq,
  output logic [IDX_W-1:0]   irqIdx,
  output logic [LVL_W-1:0]   irqLvl
);
  logic                          globalEn;
  logic [NUM_SRC-1:0]            flagQ;
  logic [NUM_SRC-1:0][LVL_W-1:0] levelQ;
  logic [NUM_SRC-1:0]            swClr;
  logic [NUM_SRC-1:0]            ackClr;
  logic                          pickValid;
  logic [IDX_W-1:0]              pickIdx;
  logic [LVL_W-1:0]              pickLvl;

  assign swClr  = (strobe.wrEn && strobe.selPend) ? ~wrData[NUM_SRC-1:0] : '0;
  assign ackClr = strobe.ackFire ? (NUM_SRC'(1) << irqIdx) : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      globalEn <= 1'b0;
      flagQ    <= '0;
      levelQ   <= '0;
    end else begin
      if (strobe.wrEn && strobe.selEn) globalEn <= wrData[0];
      flagQ <= (flagQ & ~swClr & ~ackClr) | srcPulse;
      for (int i = 0; i < NUM_SRC; i++) begin
        if (strobe.wrEn && strobe.selLvl && lvlSel == IDX_W'(i))
          levelQ[i] <= wrData[LVL_W-1:0];
      end
    end
  end

  irq_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
    .globalEn (globalEn),
    .flags    (flagQ),
    .levels   (levelQ),
    .cpuLevel (cpuLevel),
    .pickValid(pickValid),
    .pickIdx  (pickIdx),
    .pickLvl  (pickLvl)
  );

  always_ff @(posedge clk) begin
    if (!rstN || !pickValid || strobe.ackFire) begin
      irqReq <= 1'b0;
      irqIdx <= '0;
      irqLvl <= '0;
    end else begin
      irqReq <= 1'b1;
      irqIdx <= pickIdx;
      irqLvl <= pickLvl;
    end
  end

  always_comb begin
    rdData = '0;
    if (strobe.selEn)        rdData[0] = globalEn;
    else if (strobe.selPend) rdData[NUM_SRC-1:0] = flagQ;
    else if (strobe.selLvl)  rdData[LVL_W-1:0] = levelQ[lvlSel];
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : gFlagChk
    assert_flag_rise_needs_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
      $rose(flagQ[g]) |-> $past(srcPulse[g]));
    assert_pulse_wins_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
      srcPulse[g] |=> flagQ[g]);
  end

  assert_req_needs_enable_R1: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> $past(globalEn));
  assert_req_above_cpu_R5: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (irqLvl > $past(cpuLevel)));
  assert_req_level_nonzero_R4: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (irqLvl != '0));
  assert_ack_drops_req_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ackFire |=> !irqReq);
  assert_idle_outputs_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    !irqReq |-> (irqIdx == '0 && irqLvl == '0));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcPulse,
  input  logic [LVL_W-1:0]   cpuLevel,
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  input  logic               irqAck,
  output logic               irqReq,
  output logic [IDX_W-1:0]   irqIdx,
  output logic [LVL_W-1:0]   irqLvl
);
  irqStrobe_t       strobe;
  logic [IDX_W-1:0] lvlSel;

  irq_ctrl #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_ctrl (
    .regWrEn(regWrEn),
    .regAddr(regAddr),
    .irqAck (irqAck),
    .irqReqQ(irqReq),
    .strobe (strobe),
    .lvlSel (lvlSel)
  );

  irq_datapath #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .lvlSel  (lvlSel),
    .wrData  (regWrData),
    .srcPulse(srcPulse),
    .cpuLevel(cpuLevel),
    .rdData  (regRdData),
    .irqReq  (irqReq),
    .irqIdx  (irqIdx),
    .irqLvl  (irqLvl)
  );
endmodule

// File: tb/prio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module prio_irq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] srcPulse = '0;
  logic [2:0] cpuLevel = '0;
  logic       regWrEn = 1'b0;
  logic [3:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       irqAck = 1'b0;
  logic       irqReq;
  logic [2:0] irqIdx;
  logic [2:0] irqLvl;

  always #10 clk = ~clk;

  prio_irq_ctrl u_prio_irq_ctrl (
    .clk(clk), .rstN(rstN), .srcPulse(srcPulse), .cpuLevel(cpuLevel),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .irqAck(irqAck), .irqReq(irqReq),
    .irqIdx(irqIdx), .irqLvl(irqLvl)
  );

  int nChecks = 0;
  int nFail = 0;
  int cycCount = 0;
  bit done = 1'b0;

  // reference model
  logic       mEn = 1'b0;
  logic [7:0] mFlags = '0;
  logic [2:0] mLvl [8] = '{default: 3'd0};
  logic       mReq = 1'b0;
  logic [2:0] mIdx = '0;
  logic [2:0] mOutLvl = '0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] modelPick();
    logic v = 1'b0;
    logic [2:0] bi = '0;
    logic [2:0] bl = '0;
    for (int i = 0; i < 8; i++) begin
      if (mEn && mFlags[i] && mLvl[i] > cpuLevel && (!v || mLvl[i] > bl)) begin
        v = 1'b1; bi = 3'(i); bl = mLvl[i];
      end
    end
    return {v, bi, bl};
  endfunction

  // one clock with current inputs; model advances and outputs are compared (R6, R7)
  task automatic step();
    logic [6:0] p;
    logic fire;
    logic [7:0] ackM;
    logic [7:0] swC;
    p = modelPick();
    fire = irqAck && mReq;
    ackM = fire ? (8'd1 << mIdx) : 8'd0;
    swC = (regWrEn && regAddr == 4'd1) ? ~regWrData : 8'd0;
    @(posedge clk);
    mFlags = (mFlags & ~swC & ~ackM) | srcPulse;
    if (regWrEn && regAddr == 4'd0) mEn = regWrData[0];
    if (regWrEn && regAddr >= 4'd2 && regAddr < 4'd10) mLvl[regAddr - 4'd2] = regWrData[2:0];
    mReq = p[6] && !fire;
    mIdx = mReq ? p[5:3] : 3'd0;
    mOutLvl = mReq ? p[2:0] : 3'd0;
    @(negedge clk);
    check("R6 R7 lockstep", {irqReq, irqIdx, irqLvl}, {mReq, mIdx, mOutLvl});
  endtask

  task automatic cyc(logic [7:0] pulse, logic wr, logic [3:0] addr, logic [7:0] data, logic ack);
    srcPulse = pulse; regWrEn = wr; regAddr = addr; regWrData = data; irqAck = ack;
    step();
    srcPulse = '0; regWrEn = 1'b0; regWrData = '0; irqAck = 1'b0;
  endtask

  task automatic wr(logic [3:0] addr, logic [7:0] data);
    cyc(8'h00, 1'b1, addr, data, 1'b0);
  endtask

  task automatic rd(logic [3:0] addr, logic [7:0] exp, string tag);
    regAddr = addr;
    #1;
    check(tag, regRdData, exp);
  endtask

  // {expReq, expLvl, expIdx, en, pulseMask, cpuLevel}; levels s0..s7 = 0,1,3,3,5,7,2,6
  localparam logic [18:0] VEC [10] = '{
    {1'b1, 3'd3, 3'd2, 1'b1, 8'h0C, 3'd0},
    {1'b0, 3'd0, 3'd0, 1'b1, 8'h0C, 3'd3},
    {1'b1, 3'd3, 3'd2, 1'b1, 8'h0C, 3'd2},
    {1'b0, 3'd0, 3'd0, 1'b0, 8'hFF, 3'd0},
    {1'b0, 3'd0, 3'd0, 1'b1, 8'hFF, 3'd7},
    {1'b1, 3'd7, 3'd5, 1'b1, 8'hFF, 3'd6},
    {1'b0, 3'd0, 3'd0, 1'b1, 8'h01, 3'd0},
    {1'b1, 3'd6, 3'd7, 1'b1, 8'hD2, 3'd0},
    {1'b0, 3'd0, 3'd0, 1'b1, 8'h52, 3'd5},
    {1'b1, 3'd2, 3'd6, 1'b1, 8'h42, 3'd0}
  };
  localparam logic [2:0] LVLS [8] = '{3'd0, 3'd1, 3'd3, 3'd3, 3'd5, 3'd7, 3'd2, 3'd6};

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycCount++;
    if (cycCount >= 200000 && !done) begin
      done = 1'b1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 irqReq", irqReq, 0);
    check("R11 irqIdx", irqIdx, 0);
    rd(4'd0, 8'h00, "R11 enable");
    rd(4'd1, 8'h00, "R11 flags");
    rd(4'd2, 8'h00, "R11 level");
    rstN = 1'b1;

    for (int i = 0; i < 8; i++) wr(4'(i + 2), {5'd0, LVLS[i]});
    rd(4'd7, 8'h07, "R4 level readback");

    // vector table: R1 R4 R5 R6
    foreach (VEC[v]) begin
      wr(4'd1, 8'h00);
      wr(4'd0, {7'd0, VEC[v][11]});
      cpuLevel = VEC[v][2:0];
      cyc(VEC[v][10:3], 1'b0, 4'd0, 8'h00, 1'b0);
      step();
      step();
      check($sformatf("R5 R6 vector %0d", v), {irqReq, irqLvl, irqIdx}, VEC[v][18:12]);
    end

    // R2 latency: no request right after the pulse edge, request one edge later
    wr(4'd1, 8'h00);
    wr(4'd0, 8'h01);
    cpuLevel = 3'd0;
    step();
    cyc(8'h10, 1'b0, 4'd0, 8'h00, 1'b0);
    check("R2 not yet", irqReq, 0);
    step();
    check("R2 request", {irqReq, irqIdx, irqLvl}, {1'b1, 3'd4, 3'd5});

    // R3 write of ones ignored, zero clears selected flag only
    cpuLevel = 3'd7;
    wr(4'd1, 8'h00);
    wr(4'd1, 8'hFF);
    rd(4'd1, 8'h00, "R3 write one no set");
    cyc(8'h05, 1'b0, 4'd0, 8'h00, 1'b0);
    wr(4'd1, 8'hFE);
    rd(4'd1, 8'h04, "R3 selective clear");

    // R8 pulse and software clear in same cycle
    cyc(8'h04, 1'b1, 4'd1, 8'h00, 1'b0);
    rd(4'd1, 8'h04, "R8 pulse beats clear");

    // R9 acknowledge clears only presented source
    wr(4'd1, 8'h00);
    cpuLevel = 3'd0;
    cyc(8'h90, 1'b0, 4'd0, 8'h00, 1'b0);
    step();
    check("R9 presented", {irqReq, irqIdx}, {1'b1, 3'd7});
    cyc(8'h00, 1'b0, 4'd0, 8'h00, 1'b1);
    check("R9 req dropped", irqReq, 0);
    rd(4'd1, 8'h10, "R9 other flag kept");
    step();
    check("R9 next winner", {irqReq, irqIdx}, {1'b1, 3'd4});
    // R8 acknowledge and pulse of the same source
    cyc(8'h10, 1'b0, 4'd0, 8'h00, 1'b1);
    rd(4'd1, 8'h10, "R8 pulse beats ack");
    // R9 ack while idle ignored
    cpuLevel = 3'd7;
    step();
    check("R9 idle", irqReq, 0);
    cyc(8'h00, 1'b0, 4'd0, 8'h00, 1'b1);
    rd(4'd1, 8'h10, "R9 idle ack ignored");

    // R10 independence and out-of-range writes
    wr(4'd6, 8'h03);
    rd(4'd1, 8'h10, "R10 level write keeps flags");
    rd(4'd0, 8'h01, "R10 level write keeps enable");
    wr(4'd0, 8'h00);
    rd(4'd6, 8'h03, "R10 enable write keeps level");
    rd(4'd1, 8'h10, "R10 enable write keeps flags");
    wr(4'd12, 8'hFF);
    rd(4'd0, 8'h00, "R10 unmapped write");
    rd(4'd2, 8'h00, "R10 unmapped write level");
    rd(4'd12, 8'h00, "R10 unmapped read");
    wr(4'd0, 8'h01);

    // randomized lockstep against the model
    for (int c = 0; c < 4000; c++) begin
      logic [31:0] r;
      r = $urandom;
      if (c % 16 == 0) cpuLevel = 3'($urandom);
      srcPulse = 8'($urandom) & 8'($urandom) & 8'($urandom);
      irqAck = r[0];
      regWrEn = (r[3:1] == 3'd0);
      regAddr = 4'(r[7:4]);
      regWrData = (r[7:4] == 4'd0) ? {7'd0, (r[10:8] != 3'd0)} : 8'(r[23:16]) | 8'(r[31:24]);
      step();
    end
    srcPulse = '0; regWrEn = 1'b0; irqAck = 1'b0;

    done = 1'b1;
    summary();
  end
endmodule